// File: doc/BRIEF.md
# Buffered SPI Command Sequencer

This block is a single-lane SPI master that runs one half-duplex transaction per trigger out of a 128-byte scratch buffer. Software fills the buffer with the command bytes (opcode, address, dummy and any write payload) through word-wide writes. It then programs how many bytes to send and how many to receive, and triggers the engine. The engine drops chip select, sends the transmit bytes starting at buffer byte 0, and then clocks in the requested receive bytes. The received bytes are stored in the buffer directly behind the transmitted ones, so software reads them back from the byte index equal to the transmit count.

Completion uses two flags. A ready flag rises at the moment chip select returns high. A busy flag drops once the programmed deselect time has also elapsed. Software ends the session by writing zero to the control register. A software reset bit in the miscellaneous register aborts any transfer and holds the engine idle. The serial clock has no divider: it toggles every interface clock cycle, so SCK runs at half the interface clock, in SPI mode 0 only.

Top module: `bufspi_seq`

## Requirements
- R1: After reset, csN is 1 and sck is 0. The control and status registers read 0, and the misc register reads 0x0400000A (deselect 10, latency 2).
- R2: Register byte offsets are: control 0x00, transmit length 0x04, receive length 0x08, misc 0x0C, status 0x10. Buffer word k sits at 0x80+4k and holds byte 4k in bits 7:0 up to byte 4k+3 in bits 31:24. Buffer words read back as written.
- R3: Control bits are: bit 3 enable, bit 2 trigger, bit 1 ready, bit 0 busy. A write with bits 3 and 2 both set starts a transaction. A trigger with bit 3 clear starts nothing. Bit 2 always reads 0.
- R4: Transmit bytes leave buffer byte 0 upward, MSB first, on mosi. SCK idles low and each SCK level lasts one clock. mosi is stable while sck is high.
- R5: Receive bytes are built MSB first from miso, sampled on each SCK rise. They are stored from buffer byte index equal to the effective transmit count. All other buffer bytes keep their values.
- R6: csN stays low without a break for the whole transmit-then-receive sequence. The sequence contains exactly 8 × (transmit + receive) SCK rises.
- R7: Busy reads 1 from the cycle after an accepted trigger. Ready rises in the same cycle that csN rises. Writing control with bit 3 clear clears ready.
- R8: A trigger written while busy is 1 is ignored: no extra chip-select cycle and no extra SCK pulse.
- R9: Transmit count is clamped to 128. Receive count is cut to 128 minus the effective transmit count.
- R10: A receive count of 0 gives a write-only transaction. A transmit count of 0 starts reception at buffer byte 0. With both counts 0, csN never falls but ready and busy still complete.
- R11: Misc bit 28 is a software reset. While it is 1, csN is 1, sck is 0, status bits 3:0 are 0 (idle), busy and ready are 0, and triggers are ignored. The status codes are 1 for transmitting, 2 for receiving and 3 for the deselect gap.
- R12: Misc bits 4:0 (deselect) and 26:25 (latency) read back as written, and all other misc bits except 28 read 0. Busy drops deselect+1 cycles after csN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register/buffer write strobe |
| busAddr | input | 8 | Byte address of the accessed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| sck | output | 1 | Serial clock, idle low |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume a single bus port: a control write and a misc write never land in the same cycle. They also assume miso only changes after a falling SCK edge. The bench keeps to this by driving every bus access from the falling clock edge, one access at a time. Its serial slave model counts SCK falls and updates miso only at the falling clock edge after each one. Length values outside the buffer are deliberately allowed, because clamping is part of the behaviour under test.

// File: rtl/bufspi_pkg.sv
package bufspi_pkg;

  // engine state, also the value reported in the status register
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_SEND = 4'd1,
    ST_RECV = 4'd2,
    ST_GAP  = 4'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;    // load transmit shifter from buffer[idx]
    logic shiftTx;   // advance transmit shifter by one bit
    logic sampleRx;  // shift miso into receive shifter
    logic commitRx;  // write receive shifter to buffer[idx]
  } dpStrobe_t;

  // register word indices (byte offset / 4)
  localparam int REG_CTRL   = 0;
  localparam int REG_TXLEN  = 1;
  localparam int REG_RXLEN  = 2;
  localparam int REG_MISC   = 3;
  localparam int REG_STATUS = 4;

  localparam int MISC_RST_BIT = 28;

endpackage

// File: rtl/bufspi_ctrl.sv
module bufspi_ctrl
  import bufspi_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int DESEL_W   = 5,
  parameter int DESEL_RST = 10,
  parameter int LAT_RST   = 2,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int LEN_W    = IDX_W + 1,
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       regRdata,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  dpIdx,
  output logic              sck,
  output logic              csN
);

  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

  seqState_t            stateR;
  logic                 enR, readyR, wipR, swRstR;
  logic [LEN_W-1:0]     txLenR, rxLenR, leftR, rxEffR;
  logic [1:0]           latR;
  logic [DESEL_W-1:0]   deselR, gapCnt;
  logic                 sckR, csNR;
  logic [2:0]           bitCnt;
  logic [IDX_W-1:0]     idxR;

  logic                 isReg;
  logic [ADDR_W-4:0]    regIdx;
  logic                 wrCtrl, wrMisc, trigAccept, swRstNext;
  logic [LEN_W-1:0]     txEff, room, rxEff;
  logic                 lastBit, lastByte;

  assign isReg    = !busAddr[ADDR_W-1];
  assign regIdx   = busAddr[ADDR_W-2:2];
  assign wrCtrl   = busWr && isReg && (regIdx == (ADDR_W-3)'(REG_CTRL));
  assign wrMisc   = busWr && isReg && (regIdx == (ADDR_W-3)'(REG_MISC));
  assign swRstNext = wrMisc ? busWdata[MISC_RST_BIT] : swRstR;
  assign trigAccept = wrCtrl && busWdata[3] && busWdata[2] && !wipR && !swRstR;

  // clamp lengths so output plus input fits in the buffer
  assign txEff = (txLenR > BUF_LEN) ? BUF_LEN : txLenR;
  assign room  = BUF_LEN - txEff;
  assign rxEff = (rxLenR > room) ? room : rxLenR;

  assign lastBit  = (bitCnt == 3'd7);
  assign lastByte = (leftR == LEN_W'(1));

  // datapath strobes
  always_comb begin
    strobe          = '0;
    strobe.loadTx   = (trigAccept && txEff != '0) ||
                      (stateR == ST_SEND && sckR && lastBit && !lastByte);
    strobe.shiftTx  = (stateR == ST_SEND) && sckR && !lastBit;
    strobe.sampleRx = (stateR == ST_RECV) && !sckR;
    strobe.commitRx = (stateR == ST_RECV) && sckR && lastBit;
    case (stateR)
      ST_SEND: dpIdx = idxR + IDX_W'(1);
      ST_RECV: dpIdx = idxR;
      default: dpIdx = '0;
    endcase
  end

  // register read mux
  always_comb begin
    regRdata = '0;
    case (regIdx)
      (ADDR_W-3)'(REG_CTRL):   regRdata = {28'd0, enR, 1'b0, readyR, wipR};
      (ADDR_W-3)'(REG_TXLEN):  regRdata = 32'(txLenR);
      (ADDR_W-3)'(REG_RXLEN):  regRdata = 32'(rxLenR);
      (ADDR_W-3)'(REG_MISC): begin
        regRdata[MISC_RST_BIT] = swRstR;
        regRdata[26:25]        = latR;
        regRdata[DESEL_W-1:0]  = deselR;
      end
      (ADDR_W-3)'(REG_STATUS): regRdata = {28'd0, stateR};
      default:                 regRdata = '0;
    endcase
  end

  // software-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR    <= 1'b0;
      txLenR <= '0;
      rxLenR <= '0;
      swRstR <= 1'b0;
      latR   <= 2'(LAT_RST);
      deselR <= DESEL_W'(DESEL_RST);
    end else if (busWr && isReg) begin
      case (regIdx)
        (ADDR_W-3)'(REG_CTRL):  enR    <= busWdata[3];
        (ADDR_W-3)'(REG_TXLEN): txLenR <= busWdata[LEN_W-1:0];
        (ADDR_W-3)'(REG_RXLEN): rxLenR <= busWdata[LEN_W-1:0];
        (ADDR_W-3)'(REG_MISC): begin
          swRstR <= busWdata[MISC_RST_BIT];
          latR   <= busWdata[26:25];
          deselR <= busWdata[DESEL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      readyR <= 1'b0;
      wipR   <= 1'b0;
      sckR   <= 1'b0;
      csNR   <= 1'b1;
      bitCnt <= '0;
      idxR   <= '0;
      leftR  <= '0;
      rxEffR <= '0;
      gapCnt <= '0;
    end else if (swRstNext) begin
      stateR <= ST_IDLE;
      readyR <= 1'b0;
      wipR   <= 1'b0;
      sckR   <= 1'b0;
      csNR   <= 1'b1;
      bitCnt <= '0;
    end else begin
      if (wrCtrl && !busWdata[3]) readyR <= 1'b0;
      case (stateR)
        ST_IDLE: begin
          if (trigAccept) begin
            wipR   <= 1'b1;
            readyR <= 1'b0;
            sckR   <= 1'b0;
            bitCnt <= '0;
            idxR   <= '0;
            rxEffR <= rxEff;
            if (txEff != '0) begin
              stateR <= ST_SEND;
              csNR   <= 1'b0;
              leftR  <= txEff;
            end else if (rxEff != '0) begin
              stateR <= ST_RECV;
              csNR   <= 1'b0;
              leftR  <= rxEff;
            end else begin
              stateR <= ST_GAP;
              readyR <= 1'b1;
              gapCnt <= deselR;
            end
          end
        end
        ST_SEND, ST_RECV: begin
          sckR <= !sckR;
          if (sckR) begin
            if (!lastBit) begin
              bitCnt <= bitCnt + 3'd1;
            end else begin
              bitCnt <= '0;
              if (!lastByte) begin
                leftR <= leftR - LEN_W'(1);
                idxR  <= idxR + IDX_W'(1);
              end else if (stateR == ST_SEND && rxEffR != '0) begin
                stateR <= ST_RECV;
                idxR   <= idxR + IDX_W'(1);
                leftR  <= rxEffR;
              end else begin
                stateR <= ST_GAP;
                csNR   <= 1'b1;
                readyR <= 1'b1;
                gapCnt <= deselR;
              end
            end
          end
        end
        ST_GAP: begin
          sckR <= 1'b0;
          if (gapCnt == '0) begin
            stateR <= ST_IDLE;
            wipR   <= 1'b0;
          end else begin
            gapCnt <= gapCnt - DESEL_W'(1);
          end
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  assign sck = sckR;
  assign csN = csNR;

  // ---------------- assertions ----------------
  assert_sck_in_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    sckR |-> !csNR);

  assert_soft_reset_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    swRstR |-> (stateR == ST_IDLE && !wipR && !readyR && csNR));

  assert_busy_falls_after_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wipR) |-> ($past(stateR) == ST_GAP || swRstR));

  assert_ready_with_cs_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyR) |-> csNR);

  assert_busy_trigger_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWdata[3] && busWdata[2] && (stateR == ST_SEND || stateR == ST_RECV))
      |=> (stateR != ST_IDLE));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_RECV) |->
      ((LEN_W+1)'(idxR) + (LEN_W+1)'(leftR) <= (LEN_W+1)'(BUF_BYTES)));

endmodule

// File: rtl/bufspi_dp.sv
module bufspi_dp
  import bufspi_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = IDX_W + 1,
  localparam int WORD_W   = IDX_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       bufRdata,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  dpIdx,
  input  logic              miso,
  output logic              mosi
);

  logic [7:0]        bufMem [BUF_BYTES];
  logic [7:0]        txShift, rxShift;
  logic [WORD_W-1:0] wordSel;
  logic              bufWr;

  assign wordSel = busAddr[ADDR_W-2:2];
  assign bufWr   = busWr && busAddr[ADDR_W-1];

  // shared buffer: bus word writes, engine byte commits (engine wins)
  always_ff @(posedge clk) begin
    if (bufWr) begin
      for (int k = 0; k < 4; k++) begin
        bufMem[{wordSel, 2'(k)}] <= busWdata[8*k +: 8];
      end
    end
    if (strobe.commitRx) bufMem[dpIdx] <= rxShift;
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      bufRdata[8*k +: 8] = bufMem[{wordSel, 2'(k)}];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.loadTx)        txShift <= bufMem[dpIdx];
      else if (strobe.shiftTx)  txShift <= {txShift[6:0], 1'b0};
      if (strobe.sampleRx)      rxShift <= {rxShift[6:0], miso};
    end
  end

  assign mosi = txShift[7];

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftTx |-> (!strobe.loadTx && !strobe.sampleRx && !strobe.commitRx));

endmodule

// File: rtl/bufspi_seq.sv
module bufspi_seq
  import bufspi_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] dpIdx;
  logic [31:0]      regRdata, bufRdata;

  bufspi_ctrl #(.BUF_BYTES(BUF_BYTES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .regRdata (regRdata),
    .strobe   (strobe),
    .dpIdx    (dpIdx),
    .sck      (sck),
    .csN      (csN)
  );

  bufspi_dp #(.BUF_BYTES(BUF_BYTES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .bufRdata (bufRdata),
    .strobe   (strobe),
    .dpIdx    (dpIdx),
    .miso     (miso),
    .mosi     (mosi)
  );

  assign busRdata = busAddr[ADDR_W-1] ? bufRdata : regRdata;

endmodule

// File: tb/test_bufspi_seq.sv
`timescale 1ns/1ps
module test_bufspi_seq;

  localparam int BUF = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, csN, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = !clk;

  bufspi_seq i_bufspi_seq (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // ---------------- serial slave model ----------------
  logic [7:0] bufModel [BUF];
  bit   mosiLog [1024];
  int   riseCnt = 0, fallCnt = 0, csFalls = 0;
  int   respOut = 0, respSalt = 0;
  logic prevSck = 1'b0, prevCsN = 1'b1;

  function automatic logic [7:0] respByte(input int i, input int salt);
    return 8'(i * 37 + salt * 11 + 5);
  endfunction

  function automatic logic respBit(input int n);
    int j;
    logic [7:0] b;
    if (n < respOut * 8) return 1'b0;
    j = n - respOut * 8;
    b = respByte(j / 8, respSalt);
    return b[7 - (j % 8)];
  endfunction

  always @(negedge clk) begin
    if (prevCsN && !csN) begin
      riseCnt = 0;
      fallCnt = 0;
      csFalls++;
    end
    if (!csN) begin
      if (!prevSck && sck) begin
        if (riseCnt < 1024) mosiLog[riseCnt] = mosi;
        riseCnt++;
      end
      if (prevSck && !sck) fallCnt++;
    end
    miso = respBit(fallCnt);
    prevSck = sck;
    prevCsN = csN;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [31:0] modelWord(input int w);
    return {bufModel[4*w+3], bufModel[4*w+2], bufModel[4*w+1], bufModel[4*w]};
  endfunction

  task automatic loadBuffer();
    for (int w = 0; w < BUF/4; w++) busWrite(8'(8'h80 + 4*w), modelWord(w));
  endtask

  task automatic runTx(input int txLen, input int rxLen, input int salt,
                       input int desel, input bit midTrig, input string tag);
    int effOut, effIn, tot, f0, cyc, tRise, tReady, tWip, bad;
    bit first, lastCs;
    logic [31:0] v;
    effOut = (txLen > BUF) ? BUF : txLen;
    effIn  = (rxLen > BUF - effOut) ? BUF - effOut : rxLen;
    tot    = effOut + effIn;
    for (int i = 0; i < BUF; i++) bufModel[i] = 8'($urandom);
    loadBuffer();
    busWrite(8'h0C, (32'($urandom_range(0, 3)) << 25) | 32'(desel));
    busWrite(8'h04, 32'(txLen));
    busWrite(8'h08, 32'(rxLen));
    respOut = effOut; respSalt = salt; f0 = csFalls;
    busWrite(8'h00, 32'hC);
    lastCs = csN;
    if (midTrig) begin
      repeat (30) @(negedge clk);
      busWrite(8'h00, 32'hC);
    end
    tRise = -1; tReady = -1; tWip = -1; cyc = 0; first = 1;
    while (tWip < 0 && cyc < 6000) begin
      busRead(8'h00, v);
      cyc++;
      if (first && tot > 0)
        check(v[3:0] == 4'b1001, {"R3 ctrl after trigger ", tag}, v, 32'h9);
      first = 0;
      if (!lastCs && csN && tRise < 0) tRise = cyc;
      lastCs = csN;
      if (v[1] && tReady < 0) tReady = cyc;
      if (!v[0]) tWip = cyc;
    end
    check(tWip >= 0, {"R7 completion ", tag}, 32'(tWip), 32'(1));
    if (tot > 0) begin
      check(tReady == tRise, {"R7 ready with cs rise ", tag}, 32'(tReady), 32'(tRise));
      check(tWip - tRise == desel + 1, {"R12 deselect gap ", tag},
            32'(tWip - tRise), 32'(desel + 1));
      check(riseCnt == 8 * tot, {"R6 sck count ", tag}, 32'(riseCnt), 32'(8 * tot));
    end
    check(csFalls - f0 == ((tot > 0) ? 1 : 0), {"R6 R8 R10 cs cycles ", tag},
          32'(csFalls - f0), 32'((tot > 0) ? 1 : 0));
    bad = 0;
    for (int k = 0; k < 8 * effOut; k++) begin
      logic [7:0] b;
      b = bufModel[k / 8];
      if (mosiLog[k] != b[7 - (k % 8)]) bad++;
    end
    check(bad == 0, {"R4 mosi bits ", tag}, 32'(bad), 32'(0));
    for (int i = 0; i < effIn; i++) bufModel[effOut + i] = respByte(i, salt);
    for (int w = 0; w < BUF/4; w++) begin
      busRead(8'(8'h80 + 4*w), v);
      check(v == modelWord(w), {"R5 R2 buffer word ", tag}, v, modelWord(w));
    end
    busWrite(8'h00, 32'h0);
    busRead(8'h00, v);
    check(v == 32'h0, {"R7 session end ", tag}, v, 32'h0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] v;
    int f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(csN == 1'b1, "R1 csN", 32'(csN), 32'h1);
    check(sck == 1'b0, "R1 sck", 32'(sck), 32'h0);
    busRead(8'h00, v); check(v == 32'h0, "R1 ctrl", v, 32'h0);
    busRead(8'h10, v); check(v == 32'h0, "R1 status", v, 32'h0);
    busRead(8'h0C, v); check(v == 32'h0400000A, "R1 misc", v, 32'h0400000A);

    // R2 buffer word access
    busWrite(8'h94, 32'hA1B2C3D4);
    busRead(8'h94, v); check(v == 32'hA1B2C3D4, "R2 buffer readback", v, 32'hA1B2C3D4);

    // R12 misc field storage
    busWrite(8'h0C, 32'hEFFFFFFF);
    busRead(8'h0C, v); check(v == 32'h0600001F, "R12 misc fields", v, 32'h0600001F);
    busWrite(8'h0C, 32'h0400000A);

    // R3 trigger without enable
    busWrite(8'h04, 32'd2);
    f0 = csFalls;
    busWrite(8'h00, 32'h4);
    repeat (40) @(negedge clk);
    check(csFalls == f0, "R3 trigger without enable", 32'(csFalls - f0), 32'h0);
    busRead(8'h00, v); check(v[0] == 1'b0, "R3 no busy without enable", v, 32'h0);

    // directed transactions
    runTx(4, 4, 1, 10, 0, "basic");
    runTx(5, 0, 2, 3, 0, "R10 write-only");
    runTx(0, 6, 3, 0, 0, "R10 read-only");
    runTx(0, 0, 4, 2, 0, "R10 empty");
    runTx(120, 20, 5, 1, 0, "R9 rx clamp");
    runTx(200, 5, 6, 0, 0, "R9 tx clamp");
    runTx(30, 10, 7, 31, 1, "R8 busy retrigger");

    // R11 software reset abort
    for (int i = 0; i < BUF; i++) bufModel[i] = 8'(i);
    loadBuffer();
    busWrite(8'h04, 32'd40);
    busWrite(8'h08, 32'd10);
    busWrite(8'h00, 32'hC);
    repeat (50) @(negedge clk);
    busRead(8'h10, v); check(v == 32'h1, "R11 status sending", v, 32'h1);
    busWrite(8'h0C, 32'h1400000A);
    check(csN == 1'b1 && sck == 1'b0, "R11 pins idle on reset",
          {30'd0, csN, sck}, 32'h2);
    busRead(8'h10, v); check(v == 32'h0, "R11 status idle", v, 32'h0);
    busRead(8'h00, v); check(v[1:0] == 2'b00, "R11 flags cleared", v, 32'h8);
    f0 = csFalls;
    busWrite(8'h00, 32'hC);
    repeat (20) @(negedge clk);
    check(csFalls == f0, "R11 trigger held off", 32'(csFalls - f0), 32'h0);
    busRead(8'h00, v); check(v[0] == 1'b0, "R11 busy held off", v, 32'h8);
    busWrite(8'h0C, 32'h0400000A);
    busWrite(8'h00, 32'h0);
    runTx(3, 3, 8, 10, 0, "R11 recovery");

    // constrained random
    for (int t = 0; t < 8; t++) begin
      runTx($urandom_range(1, 20), $urandom_range(0, 20), 9 + t,
            $urandom_range(0, 31), 0, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule